// File: doc/BRIEF.md
# PWM Timebase with Shadowed Period

This block is the counting core of a pulse-width modulation channel. It advances a count by one on every clock cycle while it runs. In up-count mode the count climbs from zero to a top value and then wraps back to zero. In up-down mode it climbs to the top value, descends back to zero, and then repeats. Single-cycle full and empty event pulses mark the top and zero points. Downstream comparators and waveform logic use these pulses together with the live count.

Software requests a new period in clock ticks, and the block may be running when it does. The block turns the request into a peak: in up-count mode the peak is the request itself, and in up-down mode it is half the request, rounded down. The block then checks that the peak is legal and encodes it into the active period field, which the counter uses directly as its top value. Two enables select when a legal value takes effect:
- With both enables low, the value loads immediately.
- Otherwise the value waits in a shadow register, armed, until the counter reaches zero or a sync pulse arrives.

A sync pulse also forces the count to zero. Run control accepts a start command and a stop command. The stop command lets the counter finish until it next reaches zero.

The block holds three small state machines:
- **Run control.** RUN_IDLE goes to RUN_ACTIVE on start. RUN_ACTIVE goes to RUN_STOP_PEND on stop. RUN_STOP_PEND goes back to RUN_ACTIVE on start (a cancel), or to RUN_IDLE when the count reaches zero.
- **Shadow period.** SHD_EMPTY goes to SHD_ARMED on a legal write that must wait. SHD_ARMED goes back to SHD_EMPTY when its load point arrives, or when a write loads immediately. A further deferred write in SHD_ARMED stays in SHD_ARMED and replaces the shadow value.
- **Count direction.** DIR_UP goes to DIR_DOWN when the count reaches or passes the top in up-down mode. DIR_DOWN goes back to DIR_UP whenever the count lands on zero. A sync pulse, or running in up-count mode, forces DIR_UP.

Top module: `pwm_timebase`

## Requirements
- R1: With mode_updown_i = 0 (up-count), a legal request gives peak = request and field = peak-1. While running, the count steps 0, 1, …, field and then returns to 0 on the next tick.
- R2: With mode_updown_i = 1 (up-down), peak = floor(request/2) and field = peak. While running, the count rises 0 … field and falls to 0, with dir_down_o = 1 only while descending above zero.
- R3: A write whose peak is 0 or at least 2^CNT_W (65536 by default) is rejected. per_err_o is high for exactly the one cycle after the write, and per_field_o does not change.
- R4: When upd_on_zero_i and upd_on_sync_i are both low, a legal write appears on per_field_o in the cycle after the write.
- R5: When upd_on_zero_i is high, a legal write is held. It loads on the same clock edge at which the count reaches zero, so per_field_o and count_o = 0 change together.
- R6: When upd_on_sync_i is high, a held value loads on the clock edge that samples sync_i high.
- R7: sync_i forces count_o to 0 and the direction to up on the next edge, in any run state. It raises empty_o only when the timer is running.
- R8: full_o is a one-cycle pulse in the cycle in which count_o first equals the top while rising. empty_o is a one-cycle pulse in the cycle in which count_o reaches 0 while running.
- R9: cmd_start_i raises running_o in the next cycle. The count stays 0 for that cycle and then starts advancing.
- R10: cmd_stop_empty_i keeps the counter going until it next reaches 0, and running_o drops in that same cycle. A start issued while the stop is pending cancels it. While stopped, count_o stays 0.
- R11: If an immediate write lowers the top below the count, the next tick wraps to 0 without a full pulse in up-count mode, and turns downward in up-down mode.
- R12: After reset, count_o = 0, dir_down_o = 0, full_o = empty_o = running_o = per_err_o = 0, and per_field_o = INIT_FIELD (99 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_updown_i | input | 1 | 0 = up-count, 1 = up-down; change only while stopped |
| per_wr_i | input | 1 | Period write strobe |
| per_req_i | input | CNT_W+1 | Requested period in ticks |
| upd_on_zero_i | input | 1 | Defer the load to the next zero of the count |
| upd_on_sync_i | input | 1 | Defer the load to the next sync pulse |
| sync_i | input | 1 | External sync pulse |
| cmd_start_i | input | 1 | Start a free run |
| cmd_stop_empty_i | input | 1 | Stop when the count next reaches zero |
| count_o | output | CNT_W | Current count |
| dir_down_o | output | 1 | Counting down (up-down mode) |
| full_o | output | 1 | Pulse at the top |
| empty_o | output | 1 | Pulse at zero |
| running_o | output | 1 | Timer is running |
| per_err_o | output | 1 | Rejected period write |
| per_field_o | output | CNT_W | Active period field (the counter top) |

## Verification
The assertions check several properties on every cycle:
- Each running tick moves the count by exactly one or returns it to zero.
- A full pulse always lands on the top value that was in force one cycle earlier, and never lasts two cycles.
- A sync pulse always leaves the count at zero and counting up.
- A stopped timer always reads zero.
- A rejected or armed write never disturbs the active period.

Only the bench scenarios can show the rest, by comparing against a cycle model:
- the exact count sequences and period encodings of the two modes;
- the cycle in which a deferred value loads;
- stop-at-zero timing and its cancellation by a start;
- the wrap or reversal that follows a top lowered below the count.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    typedef enum logic [1:0] {
        RUN_IDLE      = 2'd0,
        RUN_ACTIVE    = 2'd1,
        RUN_STOP_PEND = 2'd2
    } run_state_e;

    typedef enum logic {
        SHD_EMPTY = 1'b0,
        SHD_ARMED = 1'b1
    } shadow_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

endpackage

// File: rtl/pwm_tb_period.sv
module pwm_tb_period
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int INIT_FIELD = 99
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_updown_i,
    input  logic             wr_i,
    input  logic [CNT_W:0]   req_i,
    input  logic             on_zero_i,
    input  logic             on_sync_i,
    input  logic             zero_evt_i,
    input  logic             sync_i,
    output logic [CNT_W-1:0] field_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] FIELD_RST = CNT_W'(INIT_FIELD);

    shadow_state_e    st_q, st_d;
    logic [CNT_W-1:0] field_q, shadow_q;
    logic             err_q;

    logic [CNT_W:0]   peak_w;
    logic             legal;
    logic [CNT_W-1:0] enc;
    logic             immediate;
    logic             load_now;
    logic             take_imm;
    logic             take_defer;

    // Request decode: halve in up-down mode, then range check and encode
    always_comb begin
        peak_w     = mode_updown_i ? (req_i >> 1) : req_i;
        legal      = (peak_w != '0) && !peak_w[CNT_W];
        enc        = mode_updown_i ? peak_w[CNT_W-1:0] : (peak_w[CNT_W-1:0] - ONE);
        immediate  = !on_zero_i && !on_sync_i;
        load_now   = (st_q == SHD_ARMED) &&
                     ((on_zero_i && zero_evt_i) || (on_sync_i && sync_i));
        take_imm   = wr_i && legal && immediate;
        take_defer = wr_i && legal && !immediate;
    end

    // Shadow state transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SHD_EMPTY: if (take_defer) st_d = SHD_ARMED;
            SHD_ARMED: begin
                if (take_defer)                 st_d = SHD_ARMED;
                else if (take_imm || load_now)  st_d = SHD_EMPTY;
            end
            default: st_d = SHD_EMPTY;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SHD_EMPTY;
        else         st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            field_q  <= FIELD_RST;
            shadow_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= wr_i && !legal;
            if (take_imm)      field_q <= enc;
            else if (load_now) field_q <= shadow_q;
            if (take_defer)    shadow_q <= enc;
        end
    end

    assign field_o = field_q;
    assign err_o   = err_q;

    // R3: a rejected write flags an error and leaves the active field alone
    a_r3_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !legal && !load_now) |=> (err_q && $stable(field_q)));

    // R5, R6: an armed value waits without disturbing the active field
    a_r5_armed_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == SHD_ARMED) && !load_now && !take_imm) |=> $stable(field_q));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_updown_i,
    input  logic             active_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             zero_evt_o
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    dir_state_e       dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             arrive;
    logic             full_q, empty_q;

    // Next count and direction
    always_comb begin
        cnt_d  = cnt_q;
        dir_d  = dir_q;
        arrive = 1'b0;
        if (sync_i) begin
            cnt_d = ZERO;
            dir_d = DIR_UP;
        end else if (active_i) begin
            if (!mode_updown_i) begin
                dir_d = DIR_UP;
                if (cnt_q >= top_i) begin
                    cnt_d = ZERO;
                end else begin
                    cnt_d  = cnt_q + ONE;
                    arrive = (cnt_d == top_i);
                end
            end else begin
                unique case (dir_q)
                    DIR_UP: begin
                        if ((cnt_q >= top_i) && (cnt_q != ZERO)) begin
                            cnt_d = cnt_q - ONE;
                            dir_d = DIR_DOWN;
                        end else begin
                            cnt_d  = cnt_q + ONE;
                            arrive = (cnt_d == top_i);
                        end
                    end
                    DIR_DOWN: cnt_d = cnt_q - ONE;
                    default:  cnt_d = ZERO;
                endcase
                if (cnt_d == ZERO) dir_d = DIR_UP;
            end
        end
    end

    assign zero_evt_o = sync_i ? active_i : (active_i && (cnt_d == ZERO));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // Event outputs, aligned with the count they describe
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            full_q  <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            full_q  <= active_i && !sync_i && arrive;
            empty_q <= zero_evt_o;
        end
    end

    assign cnt_o      = cnt_q;
    assign dir_down_o = (dir_q == DIR_DOWN);
    assign full_o     = full_q;
    assign empty_o    = empty_q;

    // R1, R2: a running tick moves the count by one or returns it to zero
    a_r1_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && !sync_i) |=>
            ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE) || (cnt_q == ZERO)));

    // R8: full lands on the top in force one cycle earlier
    a_r8_full_at_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_q |-> (cnt_q == $past(top_i)));

    // R8: full is a single-cycle pulse
    a_r8_full_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_q |=> !full_q);

    // R7: sync leaves the count at zero, counting up
    a_r7_sync_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> ((cnt_q == ZERO) && (dir_q == DIR_UP)));

endmodule

// File: rtl/pwm_tb_runctl.sv
module pwm_tb_runctl
    import pwm_tb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic stop_empty_i,
    input  logic zero_evt_i,
    output logic running_o
);

    run_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_IDLE:      if (start_i) st_d = RUN_ACTIVE;
            RUN_ACTIVE:    if (!start_i && stop_empty_i) st_d = RUN_STOP_PEND;
            RUN_STOP_PEND: begin
                if (start_i)         st_d = RUN_ACTIVE;
                else if (zero_evt_i) st_d = RUN_IDLE;
            end
            default: st_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RUN_IDLE;
        else         st_q <= st_d;
    end

    // Output process
    always_comb begin
        running_o = (st_q != RUN_IDLE);
    end

    // R9: a start command always leaves the timer running
    a_r9_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> running_o);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W      = 16,
    parameter int INIT_FIELD = 99
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_updown_i,
    input  logic             per_wr_i,
    input  logic [CNT_W:0]   per_req_i,
    input  logic             upd_on_zero_i,
    input  logic             upd_on_sync_i,
    input  logic             sync_i,
    input  logic             cmd_start_i,
    input  logic             cmd_stop_empty_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             running_o,
    output logic             per_err_o,
    output logic [CNT_W-1:0] per_field_o
);

    logic             zero_evt;
    logic             running;
    logic [CNT_W-1:0] field;

    pwm_tb_runctl u_runctl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (cmd_start_i),
        .stop_empty_i (cmd_stop_empty_i),
        .zero_evt_i   (zero_evt),
        .running_o    (running)
    );

    pwm_tb_period #(
        .CNT_W      (CNT_W),
        .INIT_FIELD (INIT_FIELD)
    ) u_period (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_updown_i (mode_updown_i),
        .wr_i          (per_wr_i),
        .req_i         (per_req_i),
        .on_zero_i     (upd_on_zero_i),
        .on_sync_i     (upd_on_sync_i),
        .zero_evt_i    (zero_evt),
        .sync_i        (sync_i),
        .field_o       (field),
        .err_o         (per_err_o)
    );

    pwm_tb_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_updown_i (mode_updown_i),
        .active_i      (running),
        .sync_i        (sync_i),
        .top_i         (field),
        .cnt_o         (count_o),
        .dir_down_o    (dir_down_o),
        .full_o        (full_o),
        .empty_o       (empty_o),
        .zero_evt_o    (zero_evt)
    );

    assign running_o   = running;
    assign per_field_o = field;

    // R10: a stopped timer always reads zero
    a_r10_idle_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o |-> (count_o == '0));

endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

    localparam int CW   = 16;
    localparam int INIT = 99;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0, wr = 1'b0, zen = 1'b0, sen = 1'b0;
    logic          sync = 1'b0, start = 1'b0, stop = 1'b0;
    logic [CW:0]   req = '0;
    logic [CW-1:0] count, field;
    logic          dir_down, full, empty, running, err;

    always #4 clk = ~clk;

    pwm_timebase dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_updown_i(mode), .per_wr_i(wr),
        .per_req_i(req), .upd_on_zero_i(zen), .upd_on_sync_i(sen), .sync_i(sync),
        .cmd_start_i(start), .cmd_stop_empty_i(stop), .count_o(count),
        .dir_down_o(dir_down), .full_o(full), .empty_o(empty), .running_o(running),
        .per_err_o(err), .per_field_o(field)
    );

    typedef struct {
        int    cnt;
        bit    dd, fu, em, run, er;
        int    fld;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0, failures = 0;
    string cur = "R12";

    // Reference model state (post-edge values)
    int m_cnt = 0, m_field = INIT, m_shadow = 0, m_state = 0;
    bit m_dd = 0, m_pend = 0, m_err = 0, m_full = 0, m_empty = 0;

    task automatic model_step();
        int nc, peak, enc, nf, ns;
        bit nd, arrive, act, zevt, legal, imm, loadn, np;
        act = (m_state != 0);
        nc = m_cnt; nd = m_dd; arrive = 0;
        if (sync) begin
            nc = 0; nd = 0;
        end else if (act) begin
            if (!mode) begin
                nd = 0;
                if (m_cnt >= m_field) nc = 0;
                else begin nc = m_cnt + 1; arrive = (nc == m_field); end
            end else begin
                if (!m_dd) begin
                    if (m_cnt >= m_field && m_cnt != 0) begin nc = m_cnt - 1; nd = 1; end
                    else begin nc = m_cnt + 1; arrive = (nc == m_field); end
                end else nc = m_cnt - 1;
                if (nc == 0) nd = 0;
            end
        end
        zevt  = sync ? act : (act && nc == 0);
        peak  = mode ? int'(req) / 2 : int'(req);
        legal = (peak > 0) && (peak < (1 << CW));
        enc   = mode ? peak : peak - 1;
        imm   = !zen && !sen;
        loadn = m_pend && ((zen && zevt) || (sen && sync));
        nf = m_field; ns = m_shadow; np = m_pend;
        if (wr && legal && imm) begin nf = enc; np = 0; end
        else if (loadn) begin nf = m_shadow; np = 0; end
        if (wr && legal && !imm) begin ns = enc; np = 1; end
        unique case (m_state)
            0: if (start) m_state = 1;
            1: if (!start && stop) m_state = 2;
            default: if (start) m_state = 1; else if (zevt) m_state = 0;
        endcase
        m_err = wr && !legal;
        m_full = act && !sync && arrive;
        m_empty = zevt;
        m_cnt = nc; m_dd = nd; m_field = nf; m_shadow = ns; m_pend = np;
    endtask

    task automatic push_exp();
        exp_t e;
        e.cnt = m_cnt; e.dd = m_dd; e.fu = m_full; e.em = m_empty;
        e.run = (m_state != 0); e.er = m_err; e.fld = m_field; e.tag = cur;
        q.push_back(e);
    endtask

    // Driver: predict, let the edge pass, queue the prediction, clear strobes
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(posedge clk);
            #1;
            push_exp();
            wr = 0; sync = 0; start = 0; stop = 0;
        end
    endtask

    // Monitor: compare design outputs against the queued predictions
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                e = q.pop_front();
                checks++;
                if (int'(count) != e.cnt || dir_down != e.dd || full != e.fu ||
                    empty != e.em || running != e.run || err != e.er ||
                    int'(field) != e.fld) begin
                    failures++;
                    $display("FAIL %s: got cnt=%0d dir=%0d full=%0d empty=%0d run=%0d err=%0d field=%0d expected cnt=%0d dir=%0d full=%0d empty=%0d run=%0d err=%0d field=%0d",
                             e.tag, count, dir_down, full, empty, running, err, field,
                             e.cnt, e.dd, e.fu, e.em, e.run, e.er, e.fld);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur = "R12"; push_exp();          // reset state
        cyc(2);

        cur = "R3";                       // illegal requests
        mode = 0; wr = 1; req = 0;      cyc(1);
        wr = 1; req = 17'd65536;        cyc(2);
        mode = 1; wr = 1; req = 1;      cyc(2);

        cur = "R4"; mode = 0; wr = 1; req = 6; cyc(2);
        cur = "R9"; start = 1; cyc(3);
        cur = "R1"; cyc(20);
        cur = "R8"; cyc(6);

        cur = "R11";                      // lower top below count, up mode
        for (int k = 0; k < 50 && m_cnt != 4; k++) cyc(1);
        wr = 1; req = 3; cyc(6);

        cur = "R5"; zen = 1; wr = 1; req = 10; cyc(25);

        cur = "R10"; stop = 1; cyc(15); cyc(4);
        start = 1; cyc(3); stop = 1; cyc(2); start = 1; cyc(14);
        stop = 1; cyc(15);

        cur = "R2"; mode = 1; zen = 0; wr = 1; req = 8; cyc(2);
        start = 1; cyc(24);

        cur = "R6"; sen = 1; wr = 1; req = 12; cyc(5);
        cur = "R7"; sync = 1; cyc(1); cyc(20);

        cur = "R11"; sen = 0;             // lower top below count, up-down mode
        for (int k = 0; k < 50 && !(m_cnt == 5 && !m_dd); k++) cyc(1);
        wr = 1; req = 4; cyc(12);

        cur = "R7"; stop = 1; cyc(10); sync = 1; cyc(3);

        cyc(2);
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R12: got %0d pending predictions expected 0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule